// File: doc/BRIEF.md
# Millisecond Timebase with Edge Capture

This block keeps an 8-bit counter that software cannot see directly. The counter steps once every 32 clocks of the oscillator. It runs from 0 up to F9h and then returns to 0. With an 8 MHz oscillator, each full lap takes exactly 1 ms. Every lap end raises a timebase flag. A control bit can stretch the lap to twice its length: it halves the step rate and leaves the terminal count as it is.

A separate external capture pin first passes through a two-flop synchronizer. A qualified edge on it, rising or falling as software selects, copies the live counter value into a read-only capture register and sets a capture flag. While that flag is pending, later edges are ignored. This keeps the first unread capture.

Both flags clear as a side effect of a read strobe on the register bus. Each flag drives its own interrupt request, gated by an enable bit.

The capture path is a two-state machine:
- `CAP_ARMED`: waiting for an edge.
- `CAP_HELD`: a capture is pending.

Its transitions are:
- `ARM_TO_HELD`: a qualified edge in `CAP_ARMED`.
- `HELD_TO_ARM`: a capture-register read in `CAP_HELD`.
- `ARMED_WAIT`: no qualified edge, so the state stays `CAP_ARMED`.
- `HELD_WAIT`: no read, so the state stays `CAP_HELD`.

Top module: `tick_capture_timer`

## Requirements
- R1: After reset the internal counter, both flags, all control bits and the capture register are zero, both interrupt outputs are low, and reading address 0 and address 1 returns 0.
- R2: The counter steps every 32 clocks and wraps from F9h to 00h. With doubling off, the timebase flag (address 0, bit 0) first sets on the 8000th clock edge after reset release and then every 8000 edges.
- R3: With the doubling bit (address 0, bit 2) set, the step comes every 64 clocks, so the first flag set moves to the 16000th edge.
- R4: A read strobe at address 0 clears the timebase flag on the following edge. `irq_tb` is high exactly while the timebase flag and its enable (address 0, bit 1) are both set.
- R5: If an overflow and a read of address 0 fall in the same cycle, the flag ends up set. The read returns the value from before the set.
- R6: A qualified edge on `cap_pin` loads the current counter value into the capture register (address 1) and sets the capture flag (address 0, bit 7). `irq_cap` is high while that flag and its enable (address 0, bit 4) are both set.
- R7: Address 0, bit 5 selects the edge: 1 selects rising, 0 selects falling. An edge of the other polarity neither sets the flag nor changes the register.
- R8: While the capture flag is set, further edges are ignored and the capture register keeps its value.
- R9: A read strobe at address 1 returns the capture register and clears the capture flag on the following edge. A capture landing in the same cycle as that read wins, so the flag ends up set.
- R10: A write to address 0 updates only bits 1, 2, 4 and 5. The flag bits 0 and 7 cannot be written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address (0 control/status, 1 capture) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; clears the flag tied to the addressed register |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| cap_pin | input | 1 | Asynchronous capture input |
| irq_tb | output | 1 | Timebase interrupt request |
| irq_cap | output | 1 | Capture interrupt request |

## Verification
The bench times the first and the repeated overflow to the exact edge.
- A wrap at FFh, or a prescaler off by one, would move the flag by whole ticks.
- A doubling mode that also shifted the terminal count would miss 16000.

It also aims a status read and a capture-register read at the very cycle in which the hardware sets the matching flag. A clear-priority design would drop that event.

Captures are checked in several ways:
- A second edge while a capture is pending must not overwrite the register. A missing lock would show the later value.
- Edges of the wrong polarity must leave the flag clear. A swapped select would capture on them.

// File: rtl/tct_pkg.sv
package tct_pkg;

    typedef enum logic {
        CAP_ARMED = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_t;

    // control/status register bit positions (address 0)
    localparam int BIT_TB_FLAG  = 0;
    localparam int BIT_TB_IE    = 1;
    localparam int BIT_DBL      = 2;
    localparam int BIT_CAP_IE   = 4;
    localparam int BIT_CAP_RISE = 5;
    localparam int BIT_CAP_FLAG = 7;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_CAP  = 1;

endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler #(
    parameter int PRESC_DIV  = 32,
    parameter bit HAS_DOUBLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic dbl,
    output logic tick
);

    localparam int PW = $clog2(PRESC_DIV);
    localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);

    logic [PW-1:0] presc_q;
    logic          wrap;

    assign wrap = (presc_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
        end else if (wrap) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    generate
        if (HAS_DOUBLE) begin : g_double
            logic half_q;

            always_ff @(posedge clk) begin
                if (rst || !dbl) begin
                    half_q <= 1'b0;
                end else if (wrap) begin
                    half_q <= ~half_q;
                end
            end

            assign tick = wrap && (!dbl || half_q);
        end else begin : g_single
            logic unused_dbl;
            assign unused_dbl = dbl;
            assign tick       = wrap;
        end
    endgenerate

endmodule

// File: rtl/tct_timebase.sv
module tct_timebase #(
    parameter int CNT_W    = 8,
    parameter int TERMINAL = 249
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERMINAL);

    logic [CNT_W-1:0] cnt_q;

    assign ovf = tick && (cnt_q == TERM_V);
    assign cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ovf) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tct_capture.sv
module tct_capture
    import tct_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_pin,
    input  logic             cap_rise,
    input  logic             cap_rd,
    input  logic [CNT_W-1:0] cnt,
    output logic             cap_flag,
    output logic [CNT_W-1:0] cap_val
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pin_s;
    logic                   qual_edge;
    logic                   load;
    cap_state_t             state_q;
    cap_state_t             state_d;

    // synchronizer chain and edge history
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], cap_pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign pin_s     = sync_q[SYNC_STAGES-1];
    assign qual_edge = cap_rise ? (pin_s && !prev_q) : (!pin_s && prev_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CAP_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_ARMED: if (qual_edge) state_d = CAP_HELD;   // ARM_TO_HELD
            CAP_HELD:  if (cap_rd)    state_d = CAP_ARMED;  // HELD_TO_ARM
            default:   state_d = CAP_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        cap_flag = 1'b0;
        load     = 1'b0;
        unique case (state_q)
            CAP_ARMED: load     = qual_edge;
            CAP_HELD:  cap_flag = 1'b1;
            default:   cap_flag = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val <= '0;
        end else if (load) begin
            cap_val <= cnt;
        end
    end

endmodule

// File: rtl/tct_regs.sv
module tct_regs
    import tct_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ovf,
    input  logic              cap_flag,
    input  logic [CNT_W-1:0]  cap_val,
    output logic              tb_flag,
    output logic              tb_ie,
    output logic              dbl,
    output logic              cap_ie,
    output logic              cap_rise,
    output logic              stat_rd,
    output logic              cap_rd
);

    logic sel_ctrl;
    logic sel_cap;
    logic unused_wdata;

    assign sel_ctrl     = (addr == ADDR_W'(ADDR_CTRL));
    assign sel_cap      = (addr == ADDR_W'(ADDR_CAP));
    assign stat_rd      = rd_en && sel_ctrl;
    assign cap_rd       = rd_en && sel_cap;
    assign unused_wdata = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_ie    <= 1'b0;
            dbl      <= 1'b0;
            cap_ie   <= 1'b0;
            cap_rise <= 1'b0;
        end else if (wr_en && sel_ctrl) begin
            tb_ie    <= wr_data[BIT_TB_IE];
            dbl      <= wr_data[BIT_DBL];
            cap_ie   <= wr_data[BIT_CAP_IE];
            cap_rise <= wr_data[BIT_CAP_RISE];
        end
    end

    // hardware set has priority over clear-on-read
    always_ff @(posedge clk) begin
        if (rst) begin
            tb_flag <= 1'b0;
        end else if (ovf) begin
            tb_flag <= 1'b1;
        end else if (stat_rd) begin
            tb_flag <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (sel_ctrl) begin
            rd_data[BIT_TB_FLAG]  = tb_flag;
            rd_data[BIT_TB_IE]    = tb_ie;
            rd_data[BIT_DBL]      = dbl;
            rd_data[BIT_CAP_IE]   = cap_ie;
            rd_data[BIT_CAP_RISE] = cap_rise;
            rd_data[BIT_CAP_FLAG] = cap_flag;
        end else if (sel_cap) begin
            rd_data = DATA_W'(cap_val);
        end
    end

endmodule

// File: rtl/tick_capture_timer.sv
module tick_capture_timer #(
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 8,
    parameter int TERMINAL    = 249,
    parameter int PRESC_DIV   = 32,
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_DOUBLE  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_pin,
    output logic              irq_tb,
    output logic              irq_cap
);

    logic             tick;
    logic             ovf;
    logic [CNT_W-1:0] cnt;
    logic             tb_flag;
    logic             tb_ie;
    logic             dbl;
    logic             cap_ie;
    logic             cap_rise;
    logic             stat_rd;
    logic             cap_rd;
    logic             cap_flag;
    logic [CNT_W-1:0] cap_val;

    tct_prescaler #(
        .PRESC_DIV (PRESC_DIV),
        .HAS_DOUBLE(HAS_DOUBLE)
    ) u_presc (
        .clk (clk),
        .rst (rst),
        .dbl (dbl),
        .tick(tick)
    );

    tct_timebase #(
        .CNT_W   (CNT_W),
        .TERMINAL(TERMINAL)
    ) u_tbase (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .cnt (cnt),
        .ovf (ovf)
    );

    tct_capture #(
        .CNT_W      (CNT_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_pin (cap_pin),
        .cap_rise(cap_rise),
        .cap_rd  (cap_rd),
        .cnt     (cnt),
        .cap_flag(cap_flag),
        .cap_val (cap_val)
    );

    tct_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wr_en   (bus_wr),
        .wr_data (bus_wdata),
        .rd_en   (bus_rd),
        .rd_data (bus_rdata),
        .ovf     (ovf),
        .cap_flag(cap_flag),
        .cap_val (cap_val),
        .tb_flag (tb_flag),
        .tb_ie   (tb_ie),
        .dbl     (dbl),
        .cap_ie  (cap_ie),
        .cap_rise(cap_rise),
        .stat_rd (stat_rd),
        .cap_rd  (cap_rd)
    );

    assign irq_tb  = tb_flag && tb_ie;
    assign irq_cap = cap_flag && cap_ie;

endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
    parameter int CNT_W    = 8,
    parameter int TERMINAL = 249
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf,
    input logic             tb_flag,
    input logic             stat_rd,
    input logic             cap_flag,
    input logic             cap_rd,
    input logic [CNT_W-1:0] cap_val
);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(TERMINAL));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    // R2
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt == '0) && tb_flag);

    // R4
    tb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stat_rd && !ovf |=> !tb_flag);

    // R8
    cap_lock_chk: assert property (@(posedge clk) disable iff (rst)
        cap_flag && !cap_rd |=> cap_flag && $stable(cap_val));

    // R9
    cap_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cap_flag && cap_rd |=> !cap_flag);

endmodule

bind tick_capture_timer tct_checker #(
    .CNT_W   (CNT_W),
    .TERMINAL(TERMINAL)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cnt     (cnt),
    .ovf     (ovf),
    .tb_flag (tb_flag),
    .stat_rd (stat_rd),
    .cap_flag(cap_flag),
    .cap_rd  (cap_rd),
    .cap_val (cap_val)
);

// File: tb/sim_tick_capture_timer.sv
module sim_tick_capture_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pin = 1'b0;
    logic       irq_tb;
    logic       irq_cap;

    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    tick_capture_timer u0 (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (addr),
        .bus_wr   (wr),
        .bus_wdata(wdata),
        .bus_rd   (rd),
        .bus_rdata(rdata),
        .cap_pin  (pin),
        .irq_tb   (irq_tb),
        .irq_cap  (irq_cap)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0; pin = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_cyc(input int unsigned n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        addr = 2'd0; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic drive_at(input int unsigned tk, input logic v);
        wait_cyc(32 * tk + 10);
        pin = v;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        chk("R1 irq_tb", irq_tb, 0);
        chk("R1 irq_cap", irq_cap, 0);
        read_reg(2'd0, d); chk("R1 status", d, 0);
        read_reg(2'd1, d); chk("R1 capture", d, 0);
    endtask

    task automatic t_write_mask();
        logic [7:0] d;
        write_ctrl(8'hFF);
        read_reg(2'd0, d); chk("R10 ctrl readback", d, 8'h36);
        write_ctrl(8'h00);
        read_reg(2'd0, d); chk("R10 ctrl cleared", d, 0);
    endtask

    task automatic t_period();
        logic [7:0] d;
        do_reset();
        write_ctrl(8'h02);
        wait_cyc(7999);   chk("R2 before first wrap", irq_tb, 0);
        @(negedge clk);   chk("R2 first wrap", irq_tb, 1);
        wait_cyc(8010);
        read_reg(2'd0, d); chk("R4 flag seen", d[0], 1);
        chk("R4 irq cleared", irq_tb, 0);
        read_reg(2'd0, d); chk("R4 flag cleared", d[0], 0);
        wait_cyc(15999);  chk("R2 before second wrap", irq_tb, 0);
        @(negedge clk);   chk("R2 second wrap", irq_tb, 1);
        wait_cyc(16010);
        read_reg(2'd0, d);
        wait_cyc(23999);
        read_reg(2'd0, d); chk("R5 read returns pre-set", d[0], 0);
        chk("R5 set wins", irq_tb, 1);
    endtask

    task automatic t_double();
        do_reset();
        write_ctrl(8'h06);
        wait_cyc(8000);   chk("R3 no wrap at 8000", irq_tb, 0);
        wait_cyc(15999);  chk("R3 before doubled wrap", irq_tb, 0);
        @(negedge clk);   chk("R3 doubled wrap", irq_tb, 1);
    endtask

    task automatic t_capture();
        logic [7:0] d;
        do_reset();
        write_ctrl(8'h30);
        drive_at(37, 1'b1);
        repeat (5) @(negedge clk);
        chk("R6 irq_cap", irq_cap, 1);
        read_reg(2'd0, d); chk("R6 status flag", d[7], 1);
        read_reg(2'd1, d); chk("R6 captured value", d, 37);
        chk("R9 read clears", irq_cap, 0);
        // falling edge while rising selected
        drive_at(40, 1'b0);
        repeat (5) @(negedge clk);
        chk("R7 wrong edge irq", irq_cap, 0);
        read_reg(2'd0, d); chk("R7 wrong edge flag", d[7], 0);
        // lock
        drive_at(50, 1'b1);
        drive_at(55, 1'b0);
        drive_at(60, 1'b1);
        repeat (5) @(negedge clk);
        read_reg(2'd1, d); chk("R8 first capture kept", d, 50);
        chk("R8 flag cleared after read", irq_cap, 0);
    endtask

    task automatic t_falling();
        logic [7:0] d;
        write_ctrl(8'h10);
        drive_at(70, 1'b0);
        repeat (5) @(negedge clk);
        read_reg(2'd0, d); chk("R7 falling flag", d[7], 1);
        read_reg(2'd1, d); chk("R7 falling value", d, 70);
        drive_at(80, 1'b1);
        repeat (5) @(negedge clk);
        chk("R7 rising ignored", irq_cap, 0);
        read_reg(2'd1, d); chk("R7 register unchanged", d, 70);
    endtask

    task automatic t_cap_setwins();
        logic [7:0] d;
        drive_at(90, 1'b0);
        @(negedge clk);
        @(negedge clk);
        read_reg(2'd1, d); chk("R9 read returns previous", d, 70);
        chk("R9 capture wins", irq_cap, 1);
        read_reg(2'd1, d); chk("R9 new value", d, 90);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_write_mask();
        t_period();
        t_double();
        t_capture();
        t_falling();
        t_cap_setwins();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule